// File: doc/BRIEF.md
# Pad Connectivity Test Chain with Interrupt-Pad Mux

This block lets a board test confirm that every digital input pad of a chip is soldered and reachable. It is used without any clock or configuration. The board holds the active-low reset pad low, which puts the block in test mode. It then drives the remaining chain pads in a fixed order and watches the interrupt pad. The chain pads are the PCI clock first, the bus grant second, and the serial-memory chip select last.

The chain is a ripple of two-input inverting cells, one cell per pad. It is evaluated from the last pad back towards reset, and the tail is tied to a level picked from the parity of the chain length. A pad that is high clamps its cell, so only pads that lie before the first high pad reach the output. Each further pad pulled low in chain order adds one inversion. The result is a square wave on the interrupt pad as the tester walks down the chain. Only digital pads belong to the chain. No-connect, analog and supply pins are never inputs to it.

Outside test mode, the interrupt pad carries the core's interrupt unchanged.

Top module: `nand_tree_testmux`

## Requirements
- R1: While `pad_rst_n` is 1, `pad_irq` equals `core_irq` whatever the chain pads carry.
- R2: While `pad_rst_n` is 0, `pad_irq` shows the chain result and does not follow `core_irq`.
- R3: With `pad_rst_n` at 0 and every bit of `pad_chain` at 1, `pad_irq` is 1.
- R4: With `pad_rst_n` at 0, `pad_chain[0]` (clock, chain position 2) at 0 and all higher bits at 1, `pad_irq` is 0.
- R5: Chain position 1 is `pad_rst_n`, and position k+2 is `pad_chain[k]`. With the first m positions low and the rest high, `pad_irq` is 1 for odd m and 0 for even m (1 ≤ m < N). Each additional in-order fall therefore toggles the output, and `pad_chain[1]` (grant) at 0 on top of R4 brings it back to 1.
- R6: With `pad_rst_n` at 0 and all of `pad_chain` at 0, `pad_irq` is 1.
- R7: Pulling a pad low while an earlier chain position is still high leaves `pad_irq` unchanged.
- R8: R3 to R7 hold for both odd and even chain lengths N ≥ 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pad_rst_n | input | 1 | Active-low reset pad; selects test mode when 0 and is chain position 1 |
| pad_chain | input | N-1 | Remaining chain pads; bit k is chain position k+2 (bit 0 clock, bit 1 grant, top bit chip select) |
| core_irq | input | 1 | Interrupt from the core logic |
| pad_irq | output | 1 | Interrupt pad: chain result in test mode, otherwise `core_irq` |

## Verification
Every result of this block is purely combinational, so each output is due in the same cycle as the stimulus that causes it, with zero register stages. The bench changes inputs just after a rising edge and samples `pad_irq` at the following falling edge. That leaves half a period for the ripple through all N cells to settle. Because each check stands alone in its own cycle, an in-order walk, an out-of-order fall and a mode change never overlap in one sample.

// File: rtl/nand_tree_pkg.sv
package nand_tree_pkg;
   // Level fed into the far end of the chain so that an all-low chain
   // resolves to 1 for either parity of the chain length.
   function automatic logic tail_tie(input int unsigned n);
      return (n % 2) == 0;
   endfunction
endpackage

// File: rtl/ntt_cell.sv
module ntt_cell (
   input  logic pad_lvl,
   input  logic down,
   output logic y
);
   // A high pad clamps the cell to 0; a low pad passes the inverse of downstream.
   always_comb y = ~(pad_lvl | down);
endmodule

// File: rtl/ntt_chain.sv
module ntt_chain #(
   parameter int unsigned N = 12
) (
   input  logic [N-1:0] lvl,
   output logic         res
);
   import nand_tree_pkg::*;
   localparam logic TIE = tail_tie(N);

   if (N < 3) begin : g_bad_len
      $error("ntt_chain: chain length must be at least 3");
   end

   logic [N:0] t;
   assign t[N] = TIE;

   for (genvar k = 0; k < N; k++) begin : g_cell
      ntt_cell u_cell (.pad_lvl(lvl[k]), .down(t[k+1]), .y(t[k]));
   end

   assign res = t[0];
endmodule

// File: rtl/ntt_outmux.sv
module ntt_outmux #(
   parameter bit GATED = 1'b0
) (
   input  logic test_n,
   input  logic tst,
   input  logic func,
   output logic y
);
   if (GATED) begin : g_andor
      always_comb y = (~test_n & tst) | (test_n & func);
   end else begin : g_sel
      always_comb y = test_n ? func : tst;
   end
endmodule

// File: rtl/nand_tree_testmux.sv
module nand_tree_testmux #(
   parameter int unsigned N         = 12,
   parameter bit          GATED_MUX = 1'b0
) (
   input  logic         pad_rst_n,
   input  logic [N-2:0] pad_chain,
   input  logic         core_irq,
   output logic         pad_irq
);
   localparam int unsigned CW = N - 1;

   if (N < 3) begin : g_bad_len
      $error("nand_tree_testmux: N must be at least 3");
   end

   logic chain_res;

   ntt_chain #(.N(N)) u_chain (
      .lvl ({pad_chain, pad_rst_n}),
      .res (chain_res)
   );

   ntt_outmux #(.GATED(GATED_MUX)) u_mux (
      .test_n (pad_rst_n),
      .tst    (chain_res),
      .func   (core_irq),
      .y      (pad_irq)
   );

   // Checks on the pad result against chain-level patterns.
   always_comb begin
      if (pad_rst_n)
         p_passthru_r1: assert (pad_irq == core_irq)
            else $error("R1 interrupt pad does not follow core");
      if (!pad_rst_n && (&pad_chain))
         p_idle_high_r3: assert (pad_irq == 1'b1)
            else $error("R3 idle chain not high");
      if (!pad_rst_n && !pad_chain[0] && (&pad_chain[CW-1:1]))
         p_clk_low_r4: assert (pad_irq == 1'b0)
            else $error("R4 clock-low step not low");
      if (!pad_rst_n && (pad_chain == '0))
         p_all_low_r6: assert (pad_irq == 1'b1)
            else $error("R6 all-low chain not high");
      if (!pad_rst_n && pad_chain[0])
         p_first_high_r7: assert (pad_irq == 1'b1)
            else $error("R7 later pad reached output past high clock pad");
   end
endmodule

// File: tb/nand_tree_testmux_bench.sv
module nand_tree_testmux_bench;
   localparam int unsigned N  = 12;
   localparam int unsigned CW = N - 1;
   localparam int unsigned NO = 9;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   int total = 0;
   int bad   = 0;

   logic          rst_n, irq, out;
   logic [CW-1:0] chain;
   logic          rst_o, irq_o, out_o;
   logic [NO-2:0] chain_o;

   nand_tree_testmux #(.N(N)) u_nand_tree_testmux (
      .pad_rst_n(rst_n), .pad_chain(chain), .core_irq(irq), .pad_irq(out));
   nand_tree_testmux #(.N(NO), .GATED_MUX(1'b1)) u_nand_tree_testmux_odd (
      .pad_rst_n(rst_o), .pad_chain(chain_o), .core_irq(irq_o), .pad_irq(out_o));

   // Row: {rst_n, chain[10:0], core_irq, expected}
   localparam int ROWS = 13;
   localparam logic [13:0] VEC [ROWS] = '{
      {1'b1, 11'h7FF, 1'b0, 1'b0},   // R1
      {1'b1, 11'h7FF, 1'b1, 1'b1},   // R1
      {1'b1, 11'h000, 1'b1, 1'b1},   // R1
      {1'b0, 11'h7FF, 1'b0, 1'b1},   // R3
      {1'b0, 11'h7FE, 1'b0, 1'b0},   // R4
      {1'b0, 11'h7FC, 1'b1, 1'b1},   // R5 grant low, R2 irq ignored
      {1'b0, 11'h7F8, 1'b0, 1'b0},   // R5
      {1'b0, 11'h7F0, 1'b0, 1'b1},   // R5
      {1'b0, 11'h400, 1'b1, 1'b1},   // R5 m=11
      {1'b0, 11'h000, 1'b0, 1'b1},   // R6
      {1'b0, 11'h7EF, 1'b1, 1'b1},   // R7
      {1'b0, 11'h7F1, 1'b0, 1'b1},   // R7
      {1'b0, 11'h3FE, 1'b0, 1'b0}    // R7
   };

   // Reference: position of first high pad decides the result.
   function automatic logic model(input logic r, input logic [31:0] c, input int n);
      int m = 0;
      logic seen = 1'b0;
      if (r) return 1'bx;
      m = 1;
      for (int k = 0; k < n - 1; k++) begin
         if (!seen && !c[k]) m++;
         else seen = 1'b1;
      end
      if (m == n) return 1'b1;
      return m[0];
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; chain = '1; irq = 1'b0;
      rst_o = 1'b0; chain_o = '1; irq_o = 1'b1;
      @(negedge clk);
      chk("R3 reset-state", out, 1'b1);
      chk("R8 odd reset-state", out_o, 1'b1);

      for (int i = 0; i < ROWS; i++) begin
         @(posedge clk);
         {rst_n, chain, irq} = VEC[i][13:1];
         @(negedge clk);
         chk($sformatf("R1-table row %0d", i), out, VEC[i][0]);
         if (!rst_n) chk("R2 model", out, model(rst_n, 32'(chain), N));
      end

      // R5: walk down the chain in order on the even instance
      @(posedge clk); rst_n = 1'b0; chain = '1; irq = 1'b0;
      for (int m = 2; m <= N; m++) begin
         @(posedge clk);
         chain[m-2] = 1'b0;
         @(negedge clk);
         chk($sformatf("R5 walk m=%0d", m), out, (m == N) ? 1'b1 : logic'(m % 2));
      end

      // R8: same walk on the odd-length instance
      @(posedge clk); rst_o = 1'b0; chain_o = '1; irq_o = 1'b1;
      for (int m = 2; m <= NO; m++) begin
         @(posedge clk);
         chain_o[m-2] = 1'b0;
         @(negedge clk);
         chk($sformatf("R8 odd walk m=%0d", m), out_o, (m == NO) ? 1'b1 : logic'(m % 2));
      end

      // R7: out-of-order falls with grant still high
      @(posedge clk); chain = '1; chain[0] = 1'b0;
      for (int k = 2; k < CW; k++) begin
         @(posedge clk);
         chain[k] = 1'b0;
         @(negedge clk);
         chk($sformatf("R7 skip pad %0d", k), out, 1'b0);
      end

      // R1/R2: leave test mode, core irq shows; return and it vanishes
      @(posedge clk); rst_n = 1'b1; chain = '0; irq = 1'b0;
      @(negedge clk); chk("R1 exit test", out, 1'b0);
      @(posedge clk); rst_n = 1'b0;
      @(negedge clk); chk("R2 re-enter test all-low", out, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule